// File: doc/BRIEF.md
# Programmable External Memory Port Controller

This block connects the register-transfer path of a small DSP to three external word memories: a read-only program store, a data DRAM and an instruction RAM. Software sees five numbered memory ports and one configuration register. Each port has a read slot and a write slot. Each slot is a 32-bit word that holds a 16-bit address and a 16-bit mode. The mode picks the target memory and the step that is added to the address after each transfer.

A slot is loaded in three register accesses. The first access to the configuration register moves the address half. The second moves the mode half and arms a pending flag. The next access to any port then copies the whole configuration into that port's read slot (for a read) or its write slot (for a write). That binding access moves no memory data. Port accesses after that become memory transfers that advance the address automatically. This holds as long as the port is the dedicated one (number 4) or one of the two status bits from the DSP is set. If neither is true, the port behaves as a plain 16-bit holding register.

The block is purely reactive. Requests and read data are combinational from the current access and the stored state. All state changes take effect at the clock edge that ends the access.

Top module: `xmem_port_ctrl`

## Requirements
- R1: The configuration register alternates between two phases on every access to select 5. In phase 0 a write loads the address half and a read returns it. In phase 1 a write loads the mode half and a read returns it, and that access arms the pending flag.
- R2: While the pending flag is armed, the next read or write of a port (select 0 to 4) copies the configuration into that port's read or write slot. It does so regardless of the status bits. That access raises no memory request and no error, returns 0 on a read, and clears the pending flag.
- R3: Any port access returns the configuration register to phase 0, so a half-finished load restarts with the address half.
- R4: A port access uses its slot only when the select is 4, or when status bit 5 (`st_b5`) or bit 6 (`st_b6`) is high. Otherwise a write stores `acc_wdata` in that port's plain register, a read returns that register, and no memory request is made.
- R5: Write modes 0x0018 and 0x0818 write the DRAM (target code 1) at the 16-bit slot address. The address is then unchanged for 0x0018 and advanced by 1 for 0x0818. `mem_wdata` carries the write data.
- R6: Write modes 0x081C and 0x101C write the instruction RAM (target code 2) at the low 10 slot-address bits, then advance the address by 1 or by 2 respectively. The write also raises `acc_err` when the slot address lies outside 0x8000 to 0x83FF.
- R7: Read modes 0x0018, 0x0818 and 0x3018 read the DRAM (target code 1) at the slot address and return `mem_rdata`. They then advance the address by 0, 1 or 32.
- R8: Read mode 0x0809 reads the ROM (target code 0) at a 20-bit address. The mode's low nibble forms bits 19:16 of that address. The address then advances by 1. The ROM is never written.
- R9: An advance changes only the address half of the slot and wraps modulo 2^16. The mode half is kept.
- R10: A slot-based access whose mode is not listed for its direction makes no memory request, returns 0 on a read, and pulses `acc_err` for that cycle.
- R11: Reset clears every slot, every plain register, the phase and the pending flag.
- R12: A port's read slot, its write slot and its plain register are independent. Binding or advancing one leaves the others as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe (wins over acc_rd) |
| acc_sel | input | 3 | 0 to 4 memory port, 5 configuration register |
| acc_wdata | input | 16 | Register write data |
| st_b5 | input | 1 | Status bit 5 |
| st_b6 | input | 1 | Status bit 6 |
| acc_rdata | output | 16 | Register read data |
| acc_err | output | 1 | Error pulse for a bad mode or an out-of-window instruction RAM write |
| mem_req | output | 1 | Memory request this cycle |
| mem_tgt | output | 2 | Target: 0 ROM, 1 DRAM, 2 instruction RAM |
| mem_addr | output | 20 | Word address |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data returned by the selected memory |

## Verification
The assertions watch the access protocol on every cycle. They check that the second configuration access arms the pending flag, and that a binding access neither requests memory nor leaves the flag set. They also check that every port access restarts the phase, that unmapped ports never reach memory, that the ROM is never written, and that a slot-based access ends in either a request or an error. Only the bench scenarios can show the address arithmetic: the steps of 0, 1, 2 and 32, wrap-around at 16 bits, the ROM's upper address nibble, the instruction RAM window error, and that read slots, write slots and plain registers stay independent. The bench also shows that reset clears a pending load.

// File: rtl/xmp_pkg.sv
// Shared types and mode encodings for the external memory port controller.
// Assumes 16-bit register data and a 4-bit ROM page extension.
package xmp_pkg;
    localparam int DW    = 16;
    localparam int PAGEW = 4;
    localparam int XAW   = DW + PAGEW;

    typedef enum logic [1:0] {
        TGT_ROM  = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_IRAM = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] mode;
    } slot_t;

    localparam logic [DW-1:0] MW_DRAM     = 16'h0018;
    localparam logic [DW-1:0] MW_DRAM_I1  = 16'h0818;
    localparam logic [DW-1:0] MW_IRAM_I1  = 16'h081C;
    localparam logic [DW-1:0] MW_IRAM_I2  = 16'h101C;
    localparam logic [DW-1:0] MR_DRAM     = 16'h0018;
    localparam logic [DW-1:0] MR_DRAM_I1  = 16'h0818;
    localparam logic [DW-1:0] MR_DRAM_I32 = 16'h3018;
    localparam logic [DW-1:0] MR_ROM_I1   = 16'h0809;
endpackage

// File: rtl/xmp_cfg_seq.sv
// Two-phase configuration register with pending-bind flag.
// Assumes cfg_acc and port_acc are never high together.
module xmp_cfg_seq
    import xmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_acc,
    input  logic          cfg_wr,
    input  logic [DW-1:0] wdata,
    input  logic          port_acc,
    output slot_t         cfg_word,
    output logic          phase,
    output logic          pending,
    output logic [DW-1:0] cfg_rdata
);
    // Read data follows the half selected by the current phase.
    assign cfg_rdata = phase ? cfg_word.mode : cfg_word.addr;

    // Phase toggle, half loads, pending arm and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word <= '0;
            phase    <= 1'b0;
            pending  <= 1'b0;
        end else if (cfg_acc) begin
            if (cfg_wr) begin
                if (phase) cfg_word.mode <= wdata;
                else       cfg_word.addr <= wdata;
            end
            phase <= ~phase;
            if (phase) pending <= 1'b1;
        end else if (port_acc) begin
            phase   <= 1'b0;
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/xmp_mode_dec.sv
// Decodes a slot's mode into target, step and external address.
// Assumes the caller qualifies the outputs with a real access.
module xmp_mode_dec
    import xmp_pkg::*;
#(
    parameter int              IRAM_AW   = 10,
    parameter logic [DW-1:0]   IRAM_BASE = 16'h8000,
    parameter int              STEPW     = 6
)(
    input  logic             is_wr,
    input  slot_t            slot,
    output logic             ok,
    output tgt_e             tgt,
    output logic [STEPW-1:0] step,
    output logic [XAW-1:0]   xaddr,
    output logic             win_err
);
    localparam int IRAM_PAD = XAW - IRAM_AW;

    // Mode lookup per direction.
    always_comb begin
        ok   = 1'b0;
        tgt  = TGT_NONE;
        step = '0;
        if (is_wr) begin
            case (slot.mode)
                MW_DRAM:    begin ok = 1'b1; tgt = TGT_DRAM; step = STEPW'(0); end
                MW_DRAM_I1: begin ok = 1'b1; tgt = TGT_DRAM; step = STEPW'(1); end
                MW_IRAM_I1: begin ok = 1'b1; tgt = TGT_IRAM; step = STEPW'(1); end
                MW_IRAM_I2: begin ok = 1'b1; tgt = TGT_IRAM; step = STEPW'(2); end
                default:    ;
            endcase
        end else begin
            case (slot.mode)
                MR_DRAM:     begin ok = 1'b1; tgt = TGT_DRAM; step = STEPW'(0);  end
                MR_DRAM_I1:  begin ok = 1'b1; tgt = TGT_DRAM; step = STEPW'(1);  end
                MR_DRAM_I32: begin ok = 1'b1; tgt = TGT_DRAM; step = STEPW'(32); end
                MR_ROM_I1:   begin ok = 1'b1; tgt = TGT_ROM;  step = STEPW'(1);  end
                default:     ;
            endcase
        end
    end

    // External address formation per target.
    always_comb begin
        case (tgt)
            TGT_ROM:  xaddr = {slot.mode[PAGEW-1:0], slot.addr};
            TGT_IRAM: xaddr = {{IRAM_PAD{1'b0}}, slot.addr[IRAM_AW-1:0]};
            default:  xaddr = {{PAGEW{1'b0}}, slot.addr};
        endcase
    end

    // Instruction RAM window test on the upper address bits.
    assign win_err = (tgt == TGT_IRAM) &&
                     (slot.addr[DW-1:IRAM_AW] != IRAM_BASE[DW-1:IRAM_AW]);
endmodule

// File: rtl/xmp_slot_bank.sv
// Per-port read slot, write slot and plain register storage.
// Assumes at most one of bind_en, inc_en, plain_we is high per cycle.
module xmp_slot_bank
    import xmp_pkg::*;
#(
    parameter int NPORTS = 5,
    parameter int SELW   = 3,
    parameter int STEPW  = 6
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SELW-1:0]  sel,
    input  logic             bind_en,
    input  logic             bind_wr,
    input  slot_t            bind_val,
    input  logic             inc_en,
    input  logic             inc_wr,
    input  logic [STEPW-1:0] inc_step,
    input  logic             plain_we,
    input  logic [DW-1:0]    wdata,
    output slot_t            rd_slot_o,
    output slot_t            wr_slot_o,
    output logic [DW-1:0]    plain_o
);
    slot_t         rd_arr    [NPORTS];
    slot_t         wr_arr    [NPORTS];
    logic [DW-1:0] plain_arr [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        slot_t         rd_q, wr_q;
        logic [DW-1:0] plain_q;
        logic          hit;
        assign hit = (sel == SELW'(p));

        // Bind or advance this port's slots, and hold its plain value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q    <= '0;
                wr_q    <= '0;
                plain_q <= '0;
            end else begin
                if (hit && bind_en) begin
                    if (bind_wr) wr_q <= bind_val;
                    else         rd_q <= bind_val;
                end else if (hit && inc_en) begin
                    if (inc_wr) wr_q.addr <= wr_q.addr + DW'(inc_step);
                    else        rd_q.addr <= rd_q.addr + DW'(inc_step);
                end
                if (hit && plain_we) plain_q <= wdata;
            end
        end

        assign rd_arr[p]    = rd_q;
        assign wr_arr[p]    = wr_q;
        assign plain_arr[p] = plain_q;
    end

    // Select the addressed port's storage.
    always_comb begin
        rd_slot_o = '0;
        wr_slot_o = '0;
        plain_o   = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel == SELW'(p)) begin
                rd_slot_o = rd_arr[p];
                wr_slot_o = wr_arr[p];
                plain_o   = plain_arr[p];
            end
        end
    end
endmodule

// File: rtl/xmem_port_ctrl.sv
// Top: routes DSP register accesses to the config sequencer, the slot bank
// and the external memory request. Assumes a single-cycle memory read path.
module xmem_port_ctrl
    import xmp_pkg::*;
#(
    parameter int            NPORTS    = 5,
    parameter int            MAP_PORT  = 4,
    parameter int            CFG_SEL   = 5,
    parameter int            SELW      = 3,
    parameter int            IRAM_AW   = 10,
    parameter logic [15:0]   IRAM_BASE = 16'h8000
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic [SELW-1:0] acc_sel,
    input  logic [DW-1:0]   acc_wdata,
    input  logic            st_b5,
    input  logic            st_b6,
    output logic [DW-1:0]   acc_rdata,
    output logic            acc_err,
    output logic            mem_req,
    output logic [1:0]      mem_tgt,
    output logic [XAW-1:0]  mem_addr,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int STEPW = 6;

    logic any_acc, is_wr, cfg_hit, port_hit, mapped, xfer;
    slot_t cfg_word, rd_slot, wr_slot, cur_slot;
    logic cfg_phase, cfg_pend;
    logic [DW-1:0] cfg_rdata, plain_val;
    logic dec_ok, dec_win_err;
    tgt_e dec_tgt;
    logic [STEPW-1:0] dec_step;
    logic [XAW-1:0] dec_xaddr;

    assign any_acc  = acc_rd | acc_wr;
    assign is_wr    = acc_wr;
    assign cfg_hit  = any_acc && (acc_sel == SELW'(CFG_SEL));
    assign port_hit = any_acc && (acc_sel < SELW'(NPORTS));
    assign mapped   = (acc_sel == SELW'(MAP_PORT)) || st_b5 || st_b6;
    assign xfer     = port_hit && !cfg_pend && mapped;
    assign cur_slot = is_wr ? wr_slot : rd_slot;

    xmp_cfg_seq u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_acc   (cfg_hit),
        .cfg_wr    (is_wr),
        .wdata     (acc_wdata),
        .port_acc  (port_hit),
        .cfg_word  (cfg_word),
        .phase     (cfg_phase),
        .pending   (cfg_pend),
        .cfg_rdata (cfg_rdata)
    );

    xmp_slot_bank #(.NPORTS(NPORTS), .SELW(SELW), .STEPW(STEPW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (acc_sel),
        .bind_en   (port_hit && cfg_pend),
        .bind_wr   (is_wr),
        .bind_val  (cfg_word),
        .inc_en    (mem_req),
        .inc_wr    (is_wr),
        .inc_step  (dec_step),
        .plain_we  (port_hit && is_wr && !cfg_pend && !mapped),
        .wdata     (acc_wdata),
        .rd_slot_o (rd_slot),
        .wr_slot_o (wr_slot),
        .plain_o   (plain_val)
    );

    xmp_mode_dec #(.IRAM_AW(IRAM_AW), .IRAM_BASE(IRAM_BASE), .STEPW(STEPW)) u_dec (
        .is_wr   (is_wr),
        .slot    (cur_slot),
        .ok      (dec_ok),
        .tgt     (dec_tgt),
        .step    (dec_step),
        .xaddr   (dec_xaddr),
        .win_err (dec_win_err)
    );

    assign mem_req   = xfer && dec_ok;
    assign mem_tgt   = dec_tgt;
    assign mem_addr  = dec_xaddr;
    assign mem_we    = mem_req && is_wr;
    assign mem_wdata = acc_wdata;
    assign acc_err   = xfer && (!dec_ok || (is_wr && dec_win_err));

    // Read data source: config half, memory word or plain register.
    always_comb begin
        acc_rdata = '0;
        if (acc_rd && !acc_wr) begin
            if (cfg_hit)
                acc_rdata = cfg_rdata;
            else if (port_hit && !cfg_pend)
                acc_rdata = mapped ? (dec_ok ? mem_rdata : '0) : plain_val;
        end
    end
endmodule

// File: rtl/xmem_port_chk.sv
// Protocol checker for xmem_port_ctrl, attached by bind below.
module xmem_port_chk #(
    parameter int NPORTS   = 5,
    parameter int MAP_PORT = 4,
    parameter int CFG_SEL  = 5,
    parameter int SELW     = 3
)(
    input logic            clk,
    input logic            rst_n,
    input logic            acc_rd,
    input logic            acc_wr,
    input logic [SELW-1:0] acc_sel,
    input logic            st_b5,
    input logic            st_b6,
    input logic            mem_req,
    input logic [1:0]      mem_tgt,
    input logic            mem_we,
    input logic            acc_err,
    input logic [15:0]     acc_rdata,
    input logic [15:0]     mem_rdata,
    input logic            cfg_phase,
    input logic            cfg_pend
);
    logic pacc, cacc, map_now;
    assign pacc    = (acc_rd | acc_wr) && (acc_sel < SELW'(NPORTS));
    assign cacc    = (acc_rd | acc_wr) && (acc_sel == SELW'(CFG_SEL));
    assign map_now = (acc_sel == SELW'(MAP_PORT)) || st_b5 || st_b6;

    a_r1_second_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (cacc && cfg_phase) |=> (cfg_pend && !cfg_phase));

    a_r2_bind_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc && cfg_pend) |-> (!mem_req && !acc_err));

    a_r2_bind_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc && cfg_pend) |=> !cfg_pend);

    a_r3_port_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        pacc |=> !cfg_phase);

    a_r4_plain_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc && !map_now) |-> !mem_req);

    a_r8_rom_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_tgt == 2'd0) |-> !mem_we);

    a_r7_read_returns_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (acc_rdata == mem_rdata));

    a_r10_req_or_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc && !cfg_pend && map_now) |-> (mem_req || acc_err));
endmodule

bind xmem_port_ctrl xmem_port_chk #(
    .NPORTS(NPORTS), .MAP_PORT(MAP_PORT), .CFG_SEL(CFG_SEL), .SELW(SELW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .st_b5     (st_b5),
    .st_b6     (st_b6),
    .mem_req   (mem_req),
    .mem_tgt   (mem_tgt),
    .mem_we    (mem_we),
    .acc_err   (acc_err),
    .acc_rdata (acc_rdata),
    .mem_rdata (mem_rdata),
    .cfg_phase (cfg_phase),
    .cfg_pend  (cfg_pend)
);

// File: tb/xmem_port_ctrl_test.sv
// Self-checking bench: vector table, then directed reset tests.
module xmem_port_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [15:0] acc_wdata = '0;
    logic        st_b5 = 1'b0, st_b6 = 1'b0;
    logic [15:0] acc_rdata;
    logic        acc_err, mem_req, mem_we;
    logic [1:0]  mem_tgt;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;

    xmem_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .st_b5(st_b5), .st_b6(st_b6),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .mem_req(mem_req),
        .mem_tgt(mem_tgt), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [2:0]  sel;
        logic        wr;
        logic        rd;
        logic [1:0]  st;   // {bit6, bit5}
        logic [15:0] wd;
        logic [15:0] md;
        logic        req;
        logic [1:0]  tgt;
        logic        we;
        logic [19:0] addr;
        logic [15:0] rdat;
        logic        err;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        '{3'd0,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd11}, // R11 plain zero
        '{3'd4,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b1,8'd10}, // R10 zero mode
        '{3'd1,1'b1,1'b0,2'd0,16'hBEEF,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd4},  // R4 plain write
        '{3'd1,1'b0,1'b1,2'd0,16'h0000,16'hDEAD,1'b0,2'd0,1'b0,20'h00000,16'hBEEF,1'b0,8'd4},  // R4 plain read
        '{3'd5,1'b1,1'b0,2'd0,16'h1234,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd1},  // R1 addr half
        '{3'd5,1'b1,1'b0,2'd0,16'h0818,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd1},  // R1 mode half
        '{3'd4,1'b1,1'b0,2'd0,16'hAAAA,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2 bind write slot
        '{3'd4,1'b1,1'b0,2'd0,16'h5555,16'h0000,1'b1,2'd1,1'b1,20'h01234,16'h0000,1'b0,8'd5},  // R5 DRAM +1
        '{3'd4,1'b1,1'b0,2'd0,16'h1111,16'h0000,1'b1,2'd1,1'b1,20'h01235,16'h0000,1'b0,8'd5},  // R5 advanced
        '{3'd4,1'b0,1'b1,2'd0,16'h0000,16'h7777,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b1,8'd12}, // R12 read slot untouched
        '{3'd5,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h1234,1'b0,8'd1},  // R1 read addr half
        '{3'd0,1'b1,1'b0,2'd0,16'h0042,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd3},  // R3 port access mid-load
        '{3'd5,1'b1,1'b0,2'd0,16'hFFFF,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd3},  // R3 lands in addr half
        '{3'd5,1'b1,1'b0,2'd0,16'h0809,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd1},
        '{3'd2,1'b0,1'b1,2'd1,16'h0000,16'h5A5A,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2 bind read slot
        '{3'd2,1'b0,1'b1,2'd1,16'h0000,16'hC0DE,1'b1,2'd0,1'b0,20'h9FFFF,16'hC0DE,1'b0,8'd8},  // R8 ROM page
        '{3'd2,1'b0,1'b1,2'd1,16'h0000,16'h0101,1'b1,2'd0,1'b0,20'h90000,16'h0101,1'b0,8'd9},  // R9 wrap, mode kept
        '{3'd2,1'b0,1'b1,2'd0,16'h0000,16'hDEAD,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd4},  // R4 unmapped
        '{3'd5,1'b1,1'b0,2'd0,16'h83FE,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd6},
        '{3'd5,1'b1,1'b0,2'd0,16'h101C,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd6},
        '{3'd3,1'b1,1'b0,2'd2,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd3,1'b1,1'b0,2'd2,16'h7777,16'h0000,1'b1,2'd2,1'b1,20'h003FE,16'h0000,1'b0,8'd6},  // R6 IRAM +2
        '{3'd3,1'b1,1'b0,2'd2,16'h8888,16'h0000,1'b1,2'd2,1'b1,20'h00000,16'h0000,1'b1,8'd6},  // R6 out of window
        '{3'd5,1'b1,1'b0,2'd0,16'hFFF0,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd5,1'b1,1'b0,2'd0,16'h3018,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd4,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd4,1'b0,1'b1,2'd0,16'h0000,16'h1357,1'b1,2'd1,1'b0,20'h0FFF0,16'h1357,1'b0,8'd7},  // R7 +32
        '{3'd4,1'b0,1'b1,2'd0,16'h0000,16'h2468,1'b1,2'd1,1'b0,20'h00010,16'h2468,1'b0,8'd9},  // R9 wrap by 32
        '{3'd5,1'b1,1'b0,2'd0,16'h0500,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd5},
        '{3'd5,1'b1,1'b0,2'd0,16'h0018,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd5},
        '{3'd0,1'b1,1'b0,2'd1,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd0,1'b1,1'b0,2'd1,16'h0A0A,16'h0000,1'b1,2'd1,1'b1,20'h00500,16'h0000,1'b0,8'd5},  // R5 no step
        '{3'd0,1'b1,1'b0,2'd1,16'h0B0B,16'h0000,1'b1,2'd1,1'b1,20'h00500,16'h0000,1'b0,8'd5},  // R5 same addr
        '{3'd0,1'b0,1'b1,2'd0,16'h0000,16'hDEAD,1'b0,2'd0,1'b0,20'h00000,16'h0042,1'b0,8'd12}, // R12 plain kept
        '{3'd5,1'b1,1'b0,2'd0,16'h0007,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd5,1'b1,1'b0,2'd0,16'h0818,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd1,1'b0,1'b1,2'd3,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd1,1'b0,1'b1,2'd3,16'h0000,16'h0F0F,1'b1,2'd1,1'b0,20'h00007,16'h0F0F,1'b0,8'd7},  // R7 +1
        '{3'd1,1'b0,1'b1,2'd3,16'h0000,16'h0E0E,1'b1,2'd1,1'b0,20'h00008,16'h0E0E,1'b0,8'd7},  // R7 advanced
        '{3'd5,1'b1,1'b0,2'd0,16'h8010,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd6},
        '{3'd5,1'b1,1'b0,2'd0,16'h081C,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd6},
        '{3'd1,1'b1,1'b0,2'd2,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd1,1'b1,1'b0,2'd2,16'h1234,16'h0000,1'b1,2'd2,1'b1,20'h00010,16'h0000,1'b0,8'd6},  // R6 IRAM +1
        '{3'd1,1'b1,1'b0,2'd2,16'h4321,16'h0000,1'b1,2'd2,1'b1,20'h00011,16'h0000,1'b0,8'd6},  // R6 advanced
        '{3'd5,1'b1,1'b0,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd10},
        '{3'd5,1'b1,1'b0,2'd0,16'h1234,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd10},
        '{3'd3,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2
        '{3'd3,1'b0,1'b1,2'd2,16'h0000,16'hFFFF,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b1,8'd10}, // R10 bad mode
        '{3'd5,1'b1,1'b0,2'd0,16'h0100,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd5,1'b1,1'b0,2'd0,16'h0018,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd7},
        '{3'd0,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2 bind while unmapped
        '{3'd0,1'b0,1'b1,2'd1,16'h0000,16'h4444,1'b1,2'd1,1'b0,20'h00100,16'h4444,1'b0,8'd7},  // R7 no step
        '{3'd0,1'b0,1'b1,2'd1,16'h0000,16'h4545,1'b1,2'd1,1'b0,20'h00100,16'h4545,1'b0,8'd7},  // R7 same addr
        '{3'd5,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0100,1'b0,8'd1},  // R1 read addr
        '{3'd5,1'b0,1'b1,2'd0,16'h0000,16'h0000,1'b0,2'd0,1'b0,20'h00000,16'h0018,1'b0,8'd1},  // R1 read mode, arms
        '{3'd0,1'b0,1'b1,2'd0,16'h0000,16'h9999,1'b0,2'd0,1'b0,20'h00000,16'h0000,1'b0,8'd2},  // R2 bind hides plain
        '{3'd0,1'b0,1'b1,2'd0,16'h0000,16'h9999,1'b0,2'd0,1'b0,20'h00000,16'h0042,1'b0,8'd4},  // R4 plain back
        '{3'd4,1'b1,1'b0,2'd0,16'h2222,16'h0000,1'b1,2'd1,1'b1,20'h01236,16'h0000,1'b0,8'd12}  // R12 write slot kept
    };

    task automatic note(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] s, input logic w, input logic r,
                         input logic [1:0] st, input logic [15:0] wd, input logic [15:0] md);
        acc_sel = s; acc_wr = w; acc_rd = r;
        st_b6 = st[1]; st_b5 = st[0];
        acc_wdata = wd; mem_rdata = md;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        drive(3'd0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector walk: drive on the falling edge, sample 1 ns later.
        for (int i = 0; i < NV; i++) begin
            bit ok;
            @(negedge clk);
            drive(VEC[i].sel, VEC[i].wr, VEC[i].rd, VEC[i].st, VEC[i].wd, VEC[i].md);
            #1;
            ok = (mem_req == VEC[i].req) && (acc_err == VEC[i].err) &&
                 (acc_rdata == VEC[i].rdat);
            if (VEC[i].req)
                ok = ok && (mem_tgt == VEC[i].tgt) && (mem_we == VEC[i].we) &&
                     (mem_addr == VEC[i].addr) &&
                     (!VEC[i].we || mem_wdata == VEC[i].wd);
            note(ok, $sformatf("R%0d vec%0d", VEC[i].tag, i),
                 $sformatf("req=%0b tgt=%0d we=%0b addr=%05h wd=%04h rd=%04h err=%0b",
                           mem_req, mem_tgt, mem_we, mem_addr, mem_wdata, acc_rdata, acc_err),
                 $sformatf("req=%0b tgt=%0d we=%0b addr=%05h wd=%04h rd=%04h err=%0b",
                           VEC[i].req, VEC[i].tgt, VEC[i].we, VEC[i].addr, VEC[i].wd,
                           VEC[i].rdat, VEC[i].err));
        end

        // R11: arm a pending load, then reset in the middle of it.
        @(negedge clk); drive(3'd5, 1'b1, 1'b0, 2'd0, 16'hABCD, 16'h0);
        @(negedge clk); drive(3'd5, 1'b1, 1'b0, 2'd0, 16'h0818, 16'h0);
        @(negedge clk); drive(3'd0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
        rst_n = 1'b0;
        #1;
        note(!mem_req && !acc_err && acc_rdata == 16'h0, "R11 idle in reset",
             $sformatf("req=%0b err=%0b rd=%04h", mem_req, acc_err, acc_rdata), "req=0 err=0 rd=0000");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R11: pending cleared and write slot zero, so port 4 sees a bad mode.
        @(negedge clk); drive(3'd4, 1'b1, 1'b0, 2'd0, 16'h3333, 16'h0);
        #1;
        note(!mem_req && acc_err, "R11 pending and slot cleared",
             $sformatf("req=%0b err=%0b", mem_req, acc_err), "req=0 err=1");

        // R11: plain register of port 1 (written earlier) is zero again.
        @(negedge clk); drive(3'd1, 1'b0, 1'b1, 2'd0, 16'h0, 16'hFFFF);
        #1;
        note(acc_rdata == 16'h0, "R11 plain cleared",
             $sformatf("%04h", acc_rdata), "0000");

        // R11: configuration register is zero and phase restarts at address half.
        @(negedge clk); drive(3'd5, 1'b0, 1'b1, 2'd0, 16'h0, 16'h0);
        #1;
        note(acc_rdata == 16'h0, "R11 config cleared",
             $sformatf("%04h", acc_rdata), "0000");

        @(negedge clk); drive(3'd0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule